// File: doc/BRIEF.md
# Clock Gating and Wake Controller

This block decides, cycle by cycle, which clock domains of a small processor system receive a clock. It produces a system clock enable, a CPU clock enable and one enable per peripheral domain. The enables are registered on an always-running reference clock, and a latch-based gating cell downstream applies each one to its domain. Software uses a small write port to program a peripheral enable register and a control register. The control register holds a master stop bit and an arm bit for idling the CPU. The same registers are visible on a combinational read port.

Two clock-off states remove the CPU's own clock, so software cannot bring the clock back and dedicated hardware paths do it instead. A master stop halts the system clock, and so every domain. Only four external wake sources end it: a wake pin, two external interrupt pins and a real-time-clock interrupt. Each of these passes through a synchronizer on the reference clock. The wake also clears the master stop bit. A CPU-only stop takes effect when the CPU signals its idle instruction while the arm bit is set. It ends on any pending interrupt whose enable bit is 1.

The controller is a three-state machine:
- `ST_RUN`: all clocks follow their enables.
- `ST_CPU_OFF`: the CPU clock is stopped.
- `ST_SYS_OFF`: the system clock is stopped.

Its transitions are:
- STOP_SYS (RUN or CPU_OFF → SYS_OFF): the master stop bit is 1. This transition has priority over all others.
- IDLE (RUN → CPU_OFF): the CPU signals idle while the arm bit is set.
- IRQ_WAKE (CPU_OFF → RUN): an enabled interrupt is pending.
- PIN_WAKE (SYS_OFF → RUN): a synchronized wake source is high. This transition also clears the stop bit.

Top module: `clkgate_wake_ctrl`

## Requirements
- R1: After reset, `sys_clk_en` and `cpu_clk_en` are 1, every `periph_clk_en` bit is 1, the domain register (address 0) reads all ones in its low NPERIPH bits, and the control register (address 1; bit 0 = master stop, bit 1 = idle arm) reads 0.
- R2: In RUN, a write to address 0 sets `periph_clk_en[i]` to data bit i after the write edge, and the register reads back the written value.
- R3: In RUN, writing 1 to control bit 0 drops `sys_clk_en`, `cpu_clk_en` and every `periph_clk_en` bit to 0 one clock edge after the write edge.
- R4: In SYS_OFF, a high level on any of `wake_pin`, `ext_irq0`, `ext_irq1` or `rtc_irq` restores the clocks on the third rising edge after it appears, and control bit 0 reads 0 from then on.
- R5: In SYS_OFF, pending enabled interrupts have no effect; the clocks stay off.
- R6: In RUN, `cpu_idle` with control bit 1 set drops `cpu_clk_en` after the edge, while `sys_clk_en` and the peripheral enables are unchanged; with bit 1 clear, `cpu_idle` has no effect.
- R7: In CPU_OFF, any bit i with `irq_pend[i]` and `irq_en[i]` both 1 restores `cpu_clk_en` after the next edge; pending bits whose enable is 0, and the wake pins, leave the CPU clock off.
- R8: Writes to either register are ignored while the CPU clock is off.
- R9: The peripheral enable bits keep their values through a system stop and wake; a domain switched off by software stays off until rewritten.
- R10: If the master stop bit becomes 1 while the CPU is idle, the block enters SYS_OFF on the next edge even with an enabled interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 domain enables, 1 control) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| cpu_idle | input | 1 | CPU executes its idle instruction |
| wake_pin | input | 1 | Asynchronous wake pin |
| ext_irq0 | input | 1 | Asynchronous external interrupt 0 |
| ext_irq1 | input | 1 | Asynchronous external interrupt 1 |
| rtc_irq | input | 1 | Asynchronous real-time-clock interrupt |
| irq_pend | input | NIRQ | Pending interrupt vector |
| irq_en | input | NIRQ | Interrupt enable vector (1 = unmasked) |
| sys_clk_en | output | 1 | System clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | NPERIPH | Per-peripheral clock enables |

## Verification
The stop-and-wake cycle is run once for each of the four wake sources. This shows that every source alone ends a system stop, each after the same synchronizer latency. In both stopped states the bench presents inputs that must not wake: an enabled interrupt during a system stop, and a masked interrupt and the wake pin during a CPU stop. This separates the two wake sets. Writes made while stopped, a stop bit set in the same cycle as an idle request, and a partial peripheral pattern carried across a stop check that the states cannot be confused with one another.

// File: rtl/cgw_pkg.sv
package cgw_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_CPU_OFF = 2'd1,
        ST_SYS_OFF = 2'd2
    } cgw_state_e;

    // wake source positions in the synchronized vector
    localparam int WK_PIN   = 0;
    localparam int WK_INT0  = 1;
    localparam int WK_INT1  = 2;
    localparam int WK_RTC   = 3;
    localparam int WK_COUNT = 4;

    // register addresses and control bit positions
    localparam int ADDR_DOM        = 0;
    localparam int ADDR_CTRL       = 1;
    localparam int CTRL_SYSDIS_BIT = 0;
    localparam int CTRL_ARM_BIT    = 1;

endpackage

// File: rtl/cgw_sync.sv
module cgw_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/cgw_regs.sv
module cgw_regs
    import cgw_pkg::*;
#(
    parameter int NPERIPH = 6,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wr_allow,
    input  logic               hw_clr_sysdis,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NPERIPH-1:0] dom_en,
    output logic               sys_dis,
    output logic               cpu_arm
);

    localparam logic [ADDR_W-1:0] A_DOM  = ADDR_W'(ADDR_DOM);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

    logic wr_dom;
    logic wr_ctrl;

    assign wr_dom  = wr_en && wr_allow && (wr_addr == A_DOM);
    assign wr_ctrl = wr_en && wr_allow && (wr_addr == A_CTRL);

    // domain enables: reset to running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dom_en <= '1;
        end else if (wr_dom) begin
            dom_en <= wr_data[NPERIPH-1:0];
        end
    end

    // master stop: software sets, hardware wake clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_dis <= 1'b0;
        end else if (wr_ctrl) begin
            sys_dis <= wr_data[CTRL_SYSDIS_BIT];
        end else if (hw_clr_sysdis) begin
            sys_dis <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_arm <= 1'b0;
        end else if (wr_ctrl) begin
            cpu_arm <= wr_data[CTRL_ARM_BIT];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_DOM) begin
            rd_data[NPERIPH-1:0] = dom_en;
        end else if (rd_addr == A_CTRL) begin
            rd_data[CTRL_SYSDIS_BIT] = sys_dis;
            rd_data[CTRL_ARM_BIT]    = cpu_arm;
        end
    end

endmodule

// File: rtl/cgw_fsm.sv
module cgw_fsm
    import cgw_pkg::*;
#(
    parameter int NIRQ = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sys_dis,
    input  logic                cpu_arm,
    input  logic                cpu_idle,
    input  logic [WK_COUNT-1:0] wake_s,
    input  logic [NIRQ-1:0]     irq_pend,
    input  logic [NIRQ-1:0]     irq_en,
    output logic                sys_on,
    output logic                cpu_on,
    output logic                clr_sysdis
);

    cgw_state_e state_q;
    cgw_state_e state_d;
    logic       irq_wake;
    logic       pin_wake;

    assign irq_wake = |(irq_pend & irq_en);
    assign pin_wake = |wake_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (sys_dis)                   state_d = ST_SYS_OFF;  // STOP_SYS
                else if (cpu_idle && cpu_arm)  state_d = ST_CPU_OFF;  // IDLE
            end
            ST_CPU_OFF: begin
                if (sys_dis)                   state_d = ST_SYS_OFF;  // STOP_SYS
                else if (irq_wake)             state_d = ST_RUN;      // IRQ_WAKE
            end
            ST_SYS_OFF: begin
                if (pin_wake)                  state_d = ST_RUN;      // PIN_WAKE
            end
            default:                           state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        sys_on     = 1'b1;
        cpu_on     = 1'b1;
        clr_sysdis = 1'b0;
        unique case (state_q)
            ST_RUN: begin
            end
            ST_CPU_OFF: begin
                cpu_on = 1'b0;
            end
            ST_SYS_OFF: begin
                sys_on     = 1'b0;
                cpu_on     = 1'b0;
                clr_sysdis = pin_wake;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/clkgate_wake_ctrl.sv
module clkgate_wake_ctrl
    import cgw_pkg::*;
#(
    parameter int NPERIPH     = 6,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int NIRQ        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               cpu_idle,
    input  logic               wake_pin,
    input  logic               ext_irq0,
    input  logic               ext_irq1,
    input  logic               rtc_irq,
    input  logic [NIRQ-1:0]    irq_pend,
    input  logic [NIRQ-1:0]    irq_en,
    output logic               sys_clk_en,
    output logic               cpu_clk_en,
    output logic [NPERIPH-1:0] periph_clk_en
);

    logic [WK_COUNT-1:0] wake_raw;
    logic [WK_COUNT-1:0] wake_s;
    logic [NPERIPH-1:0]  dom_en;
    logic                sys_dis;
    logic                cpu_arm;
    logic                sys_on;
    logic                cpu_on;
    logic                clr_sysdis;

    always_comb begin
        wake_raw          = '0;
        wake_raw[WK_PIN]  = wake_pin;
        wake_raw[WK_INT0] = ext_irq0;
        wake_raw[WK_INT1] = ext_irq1;
        wake_raw[WK_RTC]  = rtc_irq;
    end

    cgw_sync #(
        .WIDTH  (WK_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wake_raw),
        .sync_out (wake_s)
    );

    cgw_regs #(
        .NPERIPH (NPERIPH),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .wr_allow      (cpu_on),
        .hw_clr_sysdis (clr_sysdis),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .dom_en        (dom_en),
        .sys_dis       (sys_dis),
        .cpu_arm       (cpu_arm)
    );

    cgw_fsm #(
        .NIRQ (NIRQ)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_dis    (sys_dis),
        .cpu_arm    (cpu_arm),
        .cpu_idle   (cpu_idle),
        .wake_s     (wake_s),
        .irq_pend   (irq_pend),
        .irq_en     (irq_en),
        .sys_on     (sys_on),
        .cpu_on     (cpu_on),
        .clr_sysdis (clr_sysdis)
    );

    assign sys_clk_en = sys_on;
    assign cpu_clk_en = cpu_on;

    generate
        for (genvar g = 0; g < NPERIPH; g++) begin : g_dom
            assign periph_clk_en[g] = dom_en[g] & sys_on;
        end
    endgenerate

endmodule

// File: rtl/cgw_checker.sv
module cgw_checker
    import cgw_pkg::*;
#(
    parameter int NPERIPH = 6,
    parameter int NIRQ    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sys_clk_en,
    input logic                cpu_clk_en,
    input logic [NPERIPH-1:0]  periph_clk_en,
    input logic                cpu_idle,
    input logic [NIRQ-1:0]     irq_pend,
    input logic [NIRQ-1:0]     irq_en,
    input logic [WK_COUNT-1:0] wake_s,
    input logic                sys_dis,
    input logic                cpu_arm,
    input logic [NPERIPH-1:0]  dom_en
);

    p_cpu_off_with_sys_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_clk_en |-> !cpu_clk_en);

    p_periph_off_with_sys_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_clk_en |-> (periph_clk_en == '0));

    p_sys_wake_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_clk_en) |-> $past(|wake_s));

    p_stop_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_clk_en) |-> !sys_dis);

    p_stay_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clk_en && !(|wake_s)) |=> !sys_clk_en);

    p_idle_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && cpu_idle && cpu_arm && !sys_dis) |=> (!cpu_clk_en && sys_clk_en));

    p_cpu_wake_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_clk_en) && $past(sys_clk_en)) |-> $past(|(irq_pend & irq_en)));

    p_no_write_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |=> $stable(dom_en));

    p_stop_over_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && sys_clk_en && sys_dis) |=> !sys_clk_en);

endmodule

bind clkgate_wake_ctrl cgw_checker #(
    .NPERIPH (NPERIPH),
    .NIRQ    (NIRQ)
) u_cgw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .sys_clk_en    (sys_clk_en),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .cpu_idle      (cpu_idle),
    .irq_pend      (irq_pend),
    .irq_en        (irq_en),
    .wake_s        (wake_s),
    .sys_dis       (sys_dis),
    .cpu_arm       (cpu_arm),
    .dom_en        (dom_en)
);

// File: tb/clkgate_wake_ctrl_bench.sv
`timescale 1ns/1ps
module clkgate_wake_ctrl_bench;

    localparam int NP = 6;
    localparam int DW = 8;
    localparam int AW = 2;
    localparam int NI = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = 2'd1;
    logic [DW-1:0] rd_data;
    logic          cpu_idle = 1'b0;
    logic          wake_pin = 1'b0;
    logic          ext_irq0 = 1'b0;
    logic          ext_irq1 = 1'b0;
    logic          rtc_irq = 1'b0;
    logic [NI-1:0] irq_pend = '0;
    logic [NI-1:0] irq_en = '0;
    logic          sys_clk_en;
    logic          cpu_clk_en;
    logic [NP-1:0] periph_clk_en;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    typedef struct {
        string       req;
        logic [15:0] exp;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;

    clkgate_wake_ctrl #(
        .NPERIPH (NP),
        .DATA_W  (DW),
        .ADDR_W  (AW),
        .NIRQ    (NI)
    ) u_clkgate_wake_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .cpu_idle      (cpu_idle),
        .wake_pin      (wake_pin),
        .ext_irq0      (ext_irq0),
        .ext_irq1      (ext_irq1),
        .rtc_irq       (rtc_irq),
        .irq_pend      (irq_pend),
        .irq_en        (irq_en),
        .sys_clk_en    (sys_clk_en),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en)
    );

    function automatic logic [15:0] ev(bit s, bit c, logic [NP-1:0] p, logic [DW-1:0] r);
        return {s, c, p, r};
    endfunction

    // monitor: compares one queued expectation per falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] obs;
            it  = sb_q.pop_front();
            obs = {sys_clk_en, cpu_clk_en, periph_clk_en, rd_data};
            checks++;
            if (obs !== it.exp) begin
                failures++;
                $display("FAIL %s: actual %h expected %h", it.req, obs, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [15:0] exp);
        item_t it;
        it.req = req;
        it.exp = exp;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic set_src(int k, bit v);
        case (k)
            0:       wake_pin = v;
            1:       ext_irq0 = v;
            2:       ext_irq1 = v;
            default: rtc_irq  = v;
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        chk("R1 ctrl", ev(1, 1, 6'h3f, 8'h00));
        rd_addr = 2'd0;
        tick();
        chk("R1 dom", ev(1, 1, 6'h3f, 8'h3f));

        // R2 peripheral pattern
        wr(2'd0, 8'h2a);
        chk("R2", ev(1, 1, 6'h2a, 8'h2a));

        // R6 idle without arm
        rd_addr  = 2'd1;
        cpu_idle = 1'b1;
        tick();
        cpu_idle = 1'b0;
        chk("R6 unarmed", ev(1, 1, 6'h2a, 8'h00));
        wr(2'd1, 8'h02);
        chk("R6 arm", ev(1, 1, 6'h2a, 8'h02));
        cpu_idle = 1'b1;
        tick();
        cpu_idle = 1'b0;
        chk("R6 idle", ev(1, 0, 6'h2a, 8'h02));

        // R7 masked interrupt and wake pin do not wake the CPU
        irq_pend = 8'h10;
        irq_en   = 8'h01;
        tick();
        chk("R7 masked", ev(1, 0, 6'h2a, 8'h02));
        wake_pin = 1'b1;
        repeat (4) tick();
        chk("R7 pin", ev(1, 0, 6'h2a, 8'h02));
        wake_pin = 1'b0;
        repeat (3) tick();

        // R8 write while CPU off is dropped
        rd_addr = 2'd0;
        wr(2'd0, 8'h00);
        chk("R8 cpu off", ev(1, 0, 6'h2a, 8'h2a));

        // R7 enabled interrupt wakes CPU
        irq_en = 8'h10;
        tick();
        chk("R7 wake", ev(1, 1, 6'h2a, 8'h2a));
        irq_pend = '0;
        irq_en   = '0;
        rd_addr  = 2'd1;

        // R3 / R5 / R4 / R9 / R8 per wake source
        for (int k = 0; k < 4; k++) begin
            wr(2'd1, 8'h03);
            chk("R3 written", ev(1, 1, 6'h2a, 8'h03));
            tick();
            chk("R3 stopped", ev(0, 0, 6'h00, 8'h03));
            irq_pend = 8'hff;
            irq_en   = 8'hff;
            tick();
            tick();
            chk("R5", ev(0, 0, 6'h00, 8'h03));
            irq_pend = '0;
            irq_en   = '0;
            wr(2'd0, 8'h3f);
            set_src(k, 1'b1);
            tick();
            tick();
            chk("R4 latency", ev(0, 0, 6'h00, 8'h03));
            tick();
            chk("R4 R9 R8 wake", ev(1, 1, 6'h2a, 8'h02));
            set_src(k, 1'b0);
            repeat (3) tick();
        end

        // R10 stop bit set together with idle
        irq_pend = 8'h01;
        irq_en   = 8'h01;
        cpu_idle = 1'b1;
        wr(2'd1, 8'h03);
        cpu_idle = 1'b0;
        chk("R10 idle", ev(1, 0, 6'h2a, 8'h03));
        tick();
        chk("R10 stop", ev(0, 0, 6'h00, 8'h03));
        irq_pend = '0;
        irq_en   = '0;
        rtc_irq  = 1'b1;
        repeat (3) tick();
        chk("R10 R4 wake", ev(1, 1, 6'h2a, 8'h02));
        rtc_irq = 1'b0;
        repeat (3) tick();

        // R2 new pattern after wake
        rd_addr = 2'd0;
        wr(2'd0, 8'h15);
        chk("R2 rewrite", ev(1, 1, 6'h15, 8'h15));

        repeat (2) tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule